// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block turns single-word host reads and writes into the strobe and address sequence that a 32-bit EDO DRAM array expects. The array has two row-strobe banks and four byte-lane column strobes. Row and column addresses share one set of eleven multiplexed pins. Each access is one complete random cycle. The block opens the row, then presents the column, then drops the column strobes, and finally precharges before it reports ready again. Page-mode bursts are not used.

On the host side a request is taken on the clock edge where `req_i` and `ready_o` are both high. Reads return their data with a one-cycle `rvalid_o` strobe. Writes always use the early-write form, so the DRAM never drives its data pins while the controller does. Every timing figure is turned into a whole number of clock cycles at elaboration. The inputs are the clock period, a speed-grade selector and a row-to-column delay. A separate refresh scheduler claims the array through `ref_grant_i`. The controller gives way to it only between accesses.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and just after it is released, every RAS and CAS line is high and `dram_we_n_o` is high. `dram_dq_oe_o` and `rvalid_o` are low, and `ready_o` is high when no refresh grant is present.
- R2: Word address bit 22 picks the row strobe: 0 drives `dram_ras_n_o[0]` low and 1 drives `dram_ras_n_o[1]` low, and never both at once. At the RAS fall the address pins carry address bits 21..11. At the CAS fall they carry bits 10..0.
- R3: In a read, all four CAS lanes fall together, `dram_we_n_o` stays high and `dram_dq_oe_o` stays low for as long as RAS is low.
- R4: RAS is held low alone for RCD = ceil(T_RCD_NS/clk) cycles, followed by one column-setup cycle. CAS is then low for CASC = max(ceil(tCAC/clk), ceil(tRAC/clk) - RCD - 1) cycles. Read data is sampled on the edge that ends that CAS window. `rvalid_o` is high for exactly one cycle, RCD + CASC + 2 cycles after the accepting edge, and carries the sampled word.
- R5: In a write, CAS lane i falls only when byte enable bit i is set. `dram_dq_oe_o` is high and `dram_dq_o` holds the write data at the CAS fall.
- R6: In a write, `dram_we_n_o` is already low in the cycle before the CAS lanes fall.
- R7: After the CAS lanes of a write rise, `dram_dq_oe_o` and `dram_we_n_o` stay asserted for HOLD = ceil(max(tDH, 10 ns)/clk) cycles and are then released.
- R8: A write never produces an `rvalid_o` pulse.
- R9: After the access, RAS stays high for RP = ceil((tRC - tRAC)/clk) cycles. `ready_o` is low from the accepting edge for RCD + 1 + CASC + RP cycles. A request that waits through this time makes RAS fall again exactly RP + 1 cycles after it rose.
- R10: While `ref_grant_i` is high, `ready_o` is low, no request is accepted and no RAS line falls.
- R11: Each RAS low pulse lasts exactly RCD + 1 + CASC cycles. This is at least the row-access time and always below 200 us.
- R12: SPEED_GRADE 0 uses tRAC 50 ns, tCAC 13 ns, tRC 90 ns and tDH 8 ns. SPEED_GRADE 1 uses 60, 15, 110 and 10 ns. Both grades follow R4 and R9 with their own counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 23 | Word address (bank, row, column) |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables, bit i for lane i |
| ready_o | output | 1 | Controller idle and able to accept |
| rvalid_o | output | 1 | One-cycle read-data strobe |
| rdata_o | output | 32 | Returned read data |
| ref_grant_i | input | 1 | Refresh scheduler owns the array |
| dram_a_o | output | 11 | Multiplexed row/column address |
| dram_ras_n_o | output | 2 | Row strobes, one per bank, active low |
| dram_cas_n_o | output | 4 | Column strobes, one per byte lane, active low |
| dram_we_n_o | output | 1 | Write strobe, active low |
| dram_dq_o | output | 32 | Data driven to the array |
| dram_dq_i | input | 32 | Data read from the array |
| dram_dq_oe_o | output | 1 | Enable for the data bus driver |

## Verification
The bench builds two copies with the default geometry and a 4 ns clock, one for each speed grade. In the fast copy RAS is low for 13 cycles, which is 52 ns against a 50 ns row-access time, so sampling even one edge early picks up invalid data from the array model. The slow copy takes its own access latency and precharge from the same formulas, which shows that the grade selector reaches every count. Addresses at 0 and at the top of the space cover both bank strobes and the full row and column fields.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ROW,
      ST_COL,
      ST_CAS,
      ST_PRE
   } seq_state_e;

   function automatic int unsigned umax(input int unsigned x, input int unsigned y);
      return (x > y) ? x : y;
   endfunction

   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   // speed grade 0 = fast, anything else = slow
   function automatic int unsigned row_acc_ns(input int unsigned grade);
      return (grade == 0) ? 50 : 60;
   endfunction

   function automatic int unsigned col_acc_ns(input int unsigned grade);
      return (grade == 0) ? 13 : 15;
   endfunction

   function automatic int unsigned cycle_ns(input int unsigned grade);
      return (grade == 0) ? 90 : 110;
   endfunction

   function automatic int unsigned din_hold_ns(input int unsigned grade);
      return (grade == 0) ? 8 : 10;
   endfunction

   localparam int unsigned WE_HOLD_NS = 10;

endpackage

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
   parameter int unsigned BANK_W = 1,
   parameter int unsigned ROW_W  = 11,
   parameter int unsigned COL_W  = 11,
   parameter int unsigned A_W    = 11,
   localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              col_sel_i,
   output logic [BANK_W-1:0] bank_o,
   output logic [A_W-1:0]    a_o
);

   logic [ROW_W-1:0] row;
   logic [COL_W-1:0] col;

   assign col    = addr_i[COL_W-1:0];
   assign row    = addr_i[COL_W +: ROW_W];
   assign bank_o = addr_i[ADDR_W-1 -: BANK_W];

   always_comb begin
      if (col_sel_i) a_o = A_W'(col);
      else           a_o = A_W'(row);
   end

endmodule

// File: rtl/edo_strobes.sv
module edo_strobes #(
   parameter int unsigned BANKS  = 2,
   parameter int unsigned LANES  = 4,
   localparam int unsigned BANK_W = $clog2(BANKS)
) (
   input  logic              ras_act_i,
   input  logic              cas_act_i,
   input  logic              wr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [LANES-1:0]  be_i,
   output logic [BANKS-1:0]  ras_n_o,
   output logic [LANES-1:0]  cas_n_o
);

   for (genvar b = 0; b < BANKS; b++) begin : g_ras
      assign ras_n_o[b] = !(ras_act_i && (bank_i == BANK_W'(b)));
   end

   for (genvar l = 0; l < LANES; l++) begin : g_cas
      // reads open every lane, writes only the enabled ones
      assign cas_n_o[l] = !(cas_act_i && (!wr_i || be_i[l]));
   end

endmodule

// File: rtl/edo_seq.sv
module edo_seq
   import edo_ctrl_pkg::*;
#(
   parameter int unsigned RCD_CYC     = 5,
   parameter int unsigned CAS_CYC     = 7,
   parameter int unsigned RP_CYC      = 10,
   parameter int unsigned HOLD_CYC    = 3,
   parameter int unsigned RAS_MAX_CYC = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic wr_i,
   output logic idle_o,
   output logic ras_act_o,
   output logic col_sel_o,
   output logic cas_act_o,
   output logic wdrive_o,
   output logic capture_o
);

   localparam int unsigned MAXC  = umax(umax(RCD_CYC, CAS_CYC), RP_CYC);
   localparam int unsigned CNT_W = $clog2(MAXC + 1);
   localparam int unsigned RM_W  = $clog2(RAS_MAX_CYC + 1);
   localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(RCD_CYC - 1);
   localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(CAS_CYC - 1);
   localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(RP_CYC - 1);
   localparam logic [CNT_W-1:0] HOLD_N   = CNT_W'(HOLD_CYC);

   seq_state_e       state, state_nx;
   logic [CNT_W-1:0] cnt;
   logic [RM_W-1:0]  ras_low_cnt;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (start_i)         state_nx = ST_ROW;
         ST_ROW:  if (cnt == RCD_LAST) state_nx = ST_COL;
         ST_COL:                       state_nx = ST_CAS;
         ST_CAS:  if (cnt == CAS_LAST) state_nx = ST_PRE;
         ST_PRE:  if (cnt == RP_LAST)  state_nx = ST_IDLE;
         default:                      state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
      end else begin
         state <= state_nx;
         if (state_nx != state) cnt <= '0;
         else                   cnt <= cnt + 1'b1;
      end
   end

   assign idle_o    = (state == ST_IDLE);
   assign ras_act_o = (state == ST_ROW) || (state == ST_COL) || (state == ST_CAS);
   assign col_sel_o = (state == ST_COL) || (state == ST_CAS);
   assign cas_act_o = (state == ST_CAS);
   assign capture_o = (state == ST_CAS) && (cnt == CAS_LAST) && !wr_i;
   assign wdrive_o  = wr_i && ((state == ST_COL) || (state == ST_CAS) ||
                               ((state == ST_PRE) && (cnt < HOLD_N)));

   // length of the current RAS low pulse, watched against the upper limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ras_low_cnt <= '0;
      else if (ras_act_o) ras_low_cnt <= ras_low_cnt + 1'b1;
      else                ras_low_cnt <= '0;
   end

   AST_RAS_WIDTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      ras_low_cnt < RM_W'(RAS_MAX_CYC)) else $error("RAS low too long"); // R11

   AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_act_o && !$past(ras_act_o)) |-> $past(idle_o && start_i)) else $error("RAS opened without start"); // R9

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
   import edo_ctrl_pkg::*;
#(
   parameter int unsigned CLK_NS       = 4,
   parameter int unsigned SPEED_GRADE  = 0,
   parameter int unsigned BANKS        = 2,
   parameter int unsigned ROW_W        = 11,
   parameter int unsigned COL_W        = 11,
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned T_RCD_NS     = 20,
   parameter int unsigned T_RAS_MAX_NS = 200000,
   localparam int unsigned BANK_W = $clog2(BANKS),
   localparam int unsigned ADDR_W = BANK_W + ROW_W + COL_W,
   localparam int unsigned LANES  = DATA_W / 8,
   localparam int unsigned A_W    = umax(ROW_W, COL_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [LANES-1:0]  be_i,
   output logic              ready_o,
   output logic              rvalid_o,
   output logic [DATA_W-1:0] rdata_o,
   input  logic              ref_grant_i,
   output logic [A_W-1:0]    dram_a_o,
   output logic [BANKS-1:0]  dram_ras_n_o,
   output logic [LANES-1:0]  dram_cas_n_o,
   output logic              dram_we_n_o,
   output logic [DATA_W-1:0] dram_dq_o,
   input  logic [DATA_W-1:0] dram_dq_i,
   output logic              dram_dq_oe_o
);

   localparam int unsigned RAC_CYC     = ns2cyc(row_acc_ns(SPEED_GRADE), CLK_NS);
   localparam int unsigned CAC_CYC     = ns2cyc(col_acc_ns(SPEED_GRADE), CLK_NS);
   localparam int unsigned RCD_CYC     = ns2cyc(T_RCD_NS, CLK_NS);
   localparam int unsigned RAC_LEFT    = (RAC_CYC > RCD_CYC + 1) ? (RAC_CYC - RCD_CYC - 1) : 0;
   localparam int unsigned CAS_CYC     = umax(CAC_CYC, RAC_LEFT);
   localparam int unsigned RP_CYC      = ns2cyc(cycle_ns(SPEED_GRADE) - row_acc_ns(SPEED_GRADE), CLK_NS);
   localparam int unsigned HOLD_CYC    = ns2cyc(umax(din_hold_ns(SPEED_GRADE), WE_HOLD_NS), CLK_NS);
   localparam int unsigned RAS_MAX_CYC = T_RAS_MAX_NS / CLK_NS;

   // elaboration-time parameter checks
   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("BANKS must be a power of two, at least 2");
   end
   if (RCD_CYC < 1) begin : g_bad_rcd
      $error("row-to-column delay must be at least one cycle");
   end
   if (HOLD_CYC >= RP_CYC) begin : g_bad_hold
      $error("write hold must end inside the precharge window");
   end
   if (RCD_CYC + 1 + CAS_CYC >= RAS_MAX_CYC) begin : g_bad_rasmax
      $error("access would exceed the RAS pulse limit");
   end

   logic              start, idle, ras_act, col_sel, cas_act, wdrive, capture;
   logic              wr_q, cap_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [LANES-1:0]  be_q;
   logic [BANK_W-1:0] bank;

   assign ready_o = idle && !ref_grant_i;
   assign start   = req_i && ready_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else if (start) begin
         wr_q    <= we_i;
         addr_q  <= addr_i;
         wdata_q <= wdata_i;
         be_q    <= be_i;
      end
   end

   edo_seq #(
      .RCD_CYC     (RCD_CYC),
      .CAS_CYC     (CAS_CYC),
      .RP_CYC      (RP_CYC),
      .HOLD_CYC    (HOLD_CYC),
      .RAS_MAX_CYC (RAS_MAX_CYC)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .wr_i      (wr_q),
      .idle_o    (idle),
      .ras_act_o (ras_act),
      .col_sel_o (col_sel),
      .cas_act_o (cas_act),
      .wdrive_o  (wdrive),
      .capture_o (capture)
   );

   edo_addr_mux #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .A_W    (A_W)
   ) u_amux (
      .addr_i    (addr_q),
      .col_sel_i (col_sel),
      .bank_o    (bank),
      .a_o       (dram_a_o)
   );

   edo_strobes #(
      .BANKS (BANKS),
      .LANES (LANES)
   ) u_strb (
      .ras_act_i (ras_act),
      .cas_act_i (cas_act),
      .wr_i      (wr_q),
      .bank_i    (bank),
      .be_i      (be_q),
      .ras_n_o   (dram_ras_n_o),
      .cas_n_o   (dram_cas_n_o)
   );

   assign dram_we_n_o  = !wdrive;
   assign dram_dq_oe_o = wdrive;
   assign dram_dq_o    = wdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o  <= '0;
         cap_d    <= 1'b0;
         rvalid_o <= 1'b0;
      end else begin
         if (capture) rdata_o <= dram_dq_i;
         cap_d    <= capture;
         rvalid_o <= cap_d;
      end
   end

   AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~dram_ras_n_o)) else $error("two row strobes low"); // R2

   AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_q && !(&dram_cas_n_o)) |-> (dram_cas_n_o == '0)) else $error("partial read lanes"); // R3

   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_q && !(&dram_ras_n_o)) |-> (!dram_dq_oe_o && dram_we_n_o)) else $error("bus driven in read"); // R3

   AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(&dram_cas_n_o) && wr_q) |-> !$past(dram_we_n_o)) else $error("WE late for write"); // R6

   AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid_o |=> !rvalid_o) else $error("read strobe wider than one cycle"); // R4

   AST_WRITE_NO_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid_o) |-> !wr_q) else $error("read strobe after write"); // R8

   AST_GRANT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      ref_grant_i |-> !ready_o) else $error("ready during refresh grant"); // R10

endmodule

// File: tb/tb_edo_dram_ctrl.sv
module edo_dram_bfm #(
   parameter int RAC = 13,
   parameter int CAC = 4
) (
   input  logic        clk,
   input  logic [10:0] a,
   input  logic [1:0]  ras_n,
   input  logic [3:0]  cas_n,
   input  logic        we_n,
   input  logic        dq_oe,
   input  logic [31:0] dq_o,
   output logic [31:0] dq_i
);
   logic [1:0]  p_ras = 2'b11;
   logic [3:0]  p_cas = 4'hF;
   logic        p_we = 1'b1;
   int          ras_cnt = 0, cas_cnt = 0, gap = 0, gap_last = 0, ras_len = 0, oe_hold = 0;
   logic [10:0] row = '0, col = '0;
   logic        bank = 1'b0;
   logic [3:0]  lanes = '0;
   logic        we_pre = 1'b1, we_at = 1'b1, oe_at = 1'b0, read_oe = 1'b0;
   logic [31:0] dq_seen = '0;

   function automatic logic [31:0] pattern(input logic bk, input logic [10:0] r, input logic [10:0] c);
      return {c[8:0] ^ 9'h155, r, c, bk};
   endfunction

   assign dq_i = (cas_n != 4'hF && cas_cnt >= CAC && ras_cnt >= RAC) ?
                 pattern(bank, row, col) : 32'h0BAD_F00D;

   always @(negedge clk) begin
      if (ras_n != 2'b11) begin
         if (p_ras == 2'b11) begin
            row <= a; bank <= !ras_n[1]; ras_cnt <= 1; gap_last <= gap;
         end else ras_cnt <= ras_cnt + 1;
         if (we_n && dq_oe) read_oe <= 1'b1;
      end else begin
         if (p_ras != 2'b11) begin ras_len <= ras_cnt; gap <= 1; end
         else gap <= gap + 1;
         ras_cnt <= 0;
      end
      if (cas_n != 4'hF) begin
         if (p_cas == 4'hF) begin
            col <= a; lanes <= ~cas_n; we_pre <= p_we; we_at <= we_n;
            oe_at <= dq_oe; dq_seen <= dq_o; cas_cnt <= 1; oe_hold <= 0;
         end else cas_cnt <= cas_cnt + 1;
      end else begin
         cas_cnt <= 0;
         if (dq_oe) oe_hold <= oe_hold + 1;
      end
      p_ras <= ras_n; p_cas <= cas_n; p_we <= we_n;
   end
endmodule

module tb_edo_dram_ctrl;
   localparam int CLK = 4;
   function automatic int cdiv(input int n); return (n + CLK - 1) / CLK; endfunction
   function automatic int imax(input int x, input int y); return (x > y) ? x : y; endfunction

   localparam int RCD    = cdiv(20);
   localparam int RAC_F  = cdiv(50), CAC_F = cdiv(13), RP_F = cdiv(90 - 50);
   localparam int RAC_S  = cdiv(60), CAC_S = cdiv(15);
   localparam int CASC_F = imax(CAC_F, RAC_F - RCD - 1);
   localparam int CASC_S = imax(CAC_S, RAC_S - RCD - 1);
   localparam int LAT_F  = RCD + CASC_F + 2;
   localparam int LAT_S  = RCD + CASC_S + 2;
   localparam int HOLD   = cdiv(10);

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK / 2) clk = ~clk;

   logic        req = 0, we = 0, grant = 0;
   logic [22:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  be = '0;
   logic        ready, rvalid, we_n, oe;
   logic [31:0] rdata, dq_o, dq_i;
   logic [10:0] a;
   logic [1:0]  ras_n;
   logic [3:0]  cas_n;

   logic        req_s = 0;
   logic [22:0] addr_s = '0;
   logic        ready_s, rvalid_s, we_n_s, oe_s;
   logic [31:0] rdata_s, dq_o_s, dq_i_s;
   logic [10:0] a_s;
   logic [1:0]  ras_n_s;
   logic [3:0]  cas_n_s;

   int tests = 0, fails = 0;

   edo_dram_ctrl #(.CLK_NS(CLK), .SPEED_GRADE(0)) dut (
      .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .be_i(be), .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata), .ref_grant_i(grant),
      .dram_a_o(a), .dram_ras_n_o(ras_n), .dram_cas_n_o(cas_n), .dram_we_n_o(we_n),
      .dram_dq_o(dq_o), .dram_dq_i(dq_i), .dram_dq_oe_o(oe));

   edo_dram_bfm #(.RAC(RAC_F), .CAC(CAC_F)) m_f (
      .clk(clk), .a(a), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dq_oe(oe),
      .dq_o(dq_o), .dq_i(dq_i));

   edo_dram_ctrl #(.CLK_NS(CLK), .SPEED_GRADE(1)) dut_slow (
      .clk(clk), .rst_n(rst_n), .req_i(req_s), .we_i(1'b0), .addr_i(addr_s), .wdata_i(32'h0),
      .be_i(4'hF), .ready_o(ready_s), .rvalid_o(rvalid_s), .rdata_o(rdata_s), .ref_grant_i(1'b0),
      .dram_a_o(a_s), .dram_ras_n_o(ras_n_s), .dram_cas_n_o(cas_n_s), .dram_we_n_o(we_n_s),
      .dram_dq_o(dq_o_s), .dram_dq_i(dq_i_s), .dram_dq_oe_o(oe_s));

   edo_dram_bfm #(.RAC(RAC_S), .CAC(CAC_S)) m_s (
      .clk(clk), .a(a_s), .ras_n(ras_n_s), .cas_n(cas_n_s), .we_n(we_n_s), .dq_oe(oe_s),
      .dq_o(dq_o_s), .dq_i(dq_i_s));

   function automatic logic [31:0] expect_word(input logic [22:0] ad);
      return {ad[8:0] ^ 9'h155, ad[21:11], ad[10:0], ad[22]};
   endfunction

   task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   // one access on the fast copy; returns rvalid latency, rvalid count, data, cycles until ready
   task automatic issue(input logic w, input logic [22:0] ad, input logic [31:0] d, input logic [3:0] b,
                        output int lat, output int rvc, output logic [31:0] rd, output int busy);
      int n;
      @(negedge clk);
      req = 1; we = w; addr = ad; wdata = d; be = b;
      while (!ready) @(negedge clk);
      @(negedge clk);
      req = 0;
      lat = 0; rvc = 0; rd = '0; busy = 0; n = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (rvalid) begin rvc++; if (lat == 0) lat = n; rd = rdata; end
         if (ready) begin busy = n; break; end
      end
   endtask

   task automatic t_reset();
      check(ras_n == 2'b11, "R1 ras", 32'(ras_n), 32'h3);
      check(cas_n == 4'hF, "R1 cas", 32'(cas_n), 32'hF);
      check(we_n && !oe, "R1 we/oe", {30'h0, we_n, oe}, 32'h2);
      check(!rvalid && ready, "R1 rvalid/ready", {30'h0, rvalid, ready}, 32'h1);
   endtask

   task automatic t_read(input logic [22:0] ad);
      int lat, rvc, busy; logic [31:0] rd;
      issue(1'b0, ad, 32'h0, 4'h0, lat, rvc, rd, busy);
      check(lat == LAT_F, "R4 latency", 32'(lat), 32'(LAT_F));
      check(rvc == 1, "R4 single strobe", 32'(rvc), 32'h1);
      check(rd == expect_word(ad), "R4 data", rd, expect_word(ad));
      check(m_f.bank == ad[22], "R2 bank", 32'(m_f.bank), 32'(ad[22]));
      check(m_f.row == ad[21:11], "R2 row", 32'(m_f.row), 32'(ad[21:11]));
      check(m_f.col == ad[10:0], "R2 col", 32'(m_f.col), 32'(ad[10:0]));
      check(m_f.lanes == 4'hF && m_f.we_at, "R3 lanes/we", {27'h0, m_f.we_at, m_f.lanes}, 32'h1F);
      check(!m_f.read_oe, "R3 no drive", 32'(m_f.read_oe), 32'h0);
      check(m_f.ras_len == RCD + 1 + CASC_F, "R11 ras width", 32'(m_f.ras_len), 32'(RCD + 1 + CASC_F));
      check(busy == RCD + 1 + CASC_F + RP_F, "R9 busy", 32'(busy), 32'(RCD + 1 + CASC_F + RP_F));
   endtask

   task automatic t_write(input logic [22:0] ad, input logic [31:0] d, input logic [3:0] b);
      int lat, rvc, busy; logic [31:0] rd;
      issue(1'b1, ad, d, b, lat, rvc, rd, busy);
      check(rvc == 0, "R8 no rvalid", 32'(rvc), 32'h0);
      check(m_f.lanes == b, "R5 lanes", 32'(m_f.lanes), 32'(b));
      check(m_f.dq_seen == d && m_f.oe_at, "R5 data", m_f.dq_seen, d);
      check(!m_f.we_pre && !m_f.we_at, "R6 early we", {30'h0, m_f.we_pre, m_f.we_at}, 32'h0);
      check(m_f.oe_hold == HOLD, "R7 hold", 32'(m_f.oe_hold), 32'(HOLD));
      check(m_f.row == ad[21:11] && m_f.bank == ad[22], "R2 write row", 32'(m_f.row), 32'(ad[21:11]));
   endtask

   task automatic t_back_to_back(input logic [22:0] a1, input logic [22:0] a2);
      int rvc; logic [31:0] last;
      @(negedge clk);
      req = 1; we = 0; addr = a1;
      while (!ready) @(negedge clk);
      @(negedge clk);
      addr = a2;                     // second request waits through precharge
      while (!ready) @(negedge clk);
      @(negedge clk);
      req = 0;
      rvc = 0; last = '0;
      for (int i = 0; i < 200; i++) begin
         if (rvalid) begin rvc++; last = rdata; end
         if (ready) break;
         @(negedge clk);
      end
      check(m_f.gap_last == RP_F + 1, "R9 ras gap", 32'(m_f.gap_last), 32'(RP_F + 1));
      check(last == expect_word(a2), "R4 second data", last, expect_word(a2));
   endtask

   task automatic t_grant();
      logic bad;
      int lat, rvc, busy; logic [31:0] rd;
      bad = 0;
      @(negedge clk);
      grant = 1; req = 1; we = 0; addr = 23'h2A_5A5A;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (ready || ras_n != 2'b11) bad = 1;
      end
      check(!bad, "R10 held off", 32'(bad), 32'h0);
      grant = 0; req = 0;
      issue(1'b0, 23'h2A_5A5A, 32'h0, 4'h0, lat, rvc, rd, busy);
      check(rd == expect_word(23'h2A_5A5A), "R10 after grant", rd, expect_word(23'h2A_5A5A));
   endtask

   task automatic t_slow(input logic [22:0] ad);
      int n, lat; logic [31:0] rd;
      @(negedge clk);
      req_s = 1; addr_s = ad;
      while (!ready_s) @(negedge clk);
      @(negedge clk);
      req_s = 0; n = 0; lat = 0; rd = '0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         n++;
         if (rvalid_s && lat == 0) begin lat = n; rd = rdata_s; end
         if (ready_s) break;
      end
      check(lat == LAT_S, "R12 slow latency", 32'(lat), 32'(LAT_S));
      check(rd == expect_word(ad), "R12 slow data", rd, expect_word(ad));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_read(23'h00_0000);
      t_read(23'h7F_FFFF);
      t_read(23'h1D_29C7);
      t_write(23'h45_3C21, 32'hCAFE_1234, 4'hF);
      t_write(23'h7A_0011, 32'h1357_9BDF, 4'h5);
      t_write(23'h03_7FF0, 32'hA5A5_5A5A, 4'h8);
      t_back_to_back(23'h12_3456, 23'h65_4321);
      t_grant();
      t_slow(23'h5B_6E3D);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule